// File: doc/BRIEF.md
# MDIO write-verify sequencer

This block connects a byte-wide host register bus to a Clause 22 MDIO management port. Software picks a PHY address and a PHY register, writes the low data byte and then the high data byte. The high-byte write commits the 16-bit value and sends it to the PHY as a serial write frame. A status bit stays set while the transfer runs.

In verify mode the block checks each write in hardware. It reads the same PHY register back, compares all 16 bits with the committed value and sends the write again on a mismatch, up to a parameter limit of attempts. The block watches every host access, including accesses to addresses it does not decode. A read or write whose low six address bits are 0x36 may land between the two data-byte writes. Such an access leaves the staged low byte unchanged and sets a sticky flag that software can inspect.

The block has its own registers at eight addresses starting at parameter `BASE`. These are the offsets: 0 register select (bits 4:0), 1 PHY select (bits 4:0), 2 data low, 3 data high (commit), 4 control (bit 0 = verify enable), 5 status, 6 read-back low, 7 read-back high. The status bits are: bit 0 busy, bit 1 verify-fail, bit 2 write-while-busy, bit 3 hazard, bit 4 early-commit. Writing 1 clears bits 1 to 4.

Top module: `mdio_wv_seq`

## Requirements
- R1: After reset the status register reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A write to offset 3 sends one write frame to the selected PHY and register, with data {offset 3 byte, offset 2 byte}.
- R3: Frames go out MSB first, and `mdio_o` changes only while `mdc` is low. A frame is 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit PHY address, 5-bit register, turnaround, 16 data bits.
- R4: Status bit 0 reads 1 no later than two cycles after the commit write. It stays 1 until the last frame of the operation has ended.
- R5: A commit write in the cycle right after a data-low write starts nothing and sets sticky status bit 4.
- R6: Between a data-low write and the commit, any host read or write with address bits 5:0 = 6'h36 sets sticky status bit 3 and leaves the staged low byte unchanged. No other access sets bit 3.
- R7: With control bit 0 set, each write frame is followed by a read frame of the same register. If the 16 bits read back differ from the committed value, the write and the read are repeated.
- R8: After MAX_TRY failed compares, busy clears and status bit 1 is set. Offsets 6 and 7 then hold the last value read back.
- R9: Writes to offsets 0 to 3 while busy are ignored and set sticky status bit 2. Writing 1 to that bit clears it.
- R10: The `mdc` period is DIV clocks. During turnaround and data of a read frame `mdio_oe` is 0, and the 16 data bits are sampled from `mdio_i` on the rising edges of `mdc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host address, decoded for all traffic |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read data for the current address |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with DIV = 4 and the default MAX_TRY = 3. Each frame then takes 256 clocks, so a full retry exhaustion (three writes and three reads) runs in a few thousand cycles. A small MDC period makes the half-period counter wrap at its shortest legal length. A behavioural PHY in the bench corrupts a chosen number of read-backs, which drives both the single-retry case and the exhaustion case.

// File: rtl/mdio_wv_pkg.sv
package mdio_wv_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WRITE = 2'd1,
    SQ_READ  = 2'd2
  } seq_state_t;

  localparam logic [2:0] OFF_REGSEL = 3'd0;
  localparam logic [2:0] OFF_PHYSEL = 3'd1;
  localparam logic [2:0] OFF_DLO    = 3'd2;
  localparam logic [2:0] OFF_DHI    = 3'd3;
  localparam logic [2:0] OFF_CTRL   = 3'd4;
  localparam logic [2:0] OFF_STAT   = 3'd5;
  localparam logic [2:0] OFF_RBLO   = 3'd6;
  localparam logic [2:0] OFF_RBHI   = 3'd7;

  localparam logic [5:0] HAZARD_LOW6 = 6'h36;
  localparam int         FRAME_BITS  = 64;
  localparam logic [5:0] DRIVE_LAST  = 6'd45;
  localparam logic [5:0] DATA_FIRST  = 6'd48;
endpackage

// File: rtl/mdio_wv_regs.sv
module mdio_wv_regs
  import mdio_wv_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 'hE80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              busy,
  input  logic              vfail_set,
  input  logic              rb_load,
  input  logic [15:0]       rb_val,
  output logic              launch,
  output logic              verify_en,
  output logic [15:0]       stage_data,
  output logic [4:0]        phy_addr,
  output logic [4:0]        reg_addr
);
  logic       hit;
  logic [2:0] off;
  logic       wr_regsel, wr_physel, wr_dlo, wr_dhi, wr_ctrl, wr_stat, cfg_wr;

  logic [4:0]  regsel_q, regsel_n, physel_q, physel_n;
  logic [7:0]  dlo_q, dlo_n, dhi_q, dhi_n;
  logic        verify_q, verify_n;
  logic        vfail_q, vfail_n, wwb_q, wwb_n, hazard_q, hazard_n, early_q, early_n;
  logic        lo_last_q, lo_last_n, pending_q, pending_n;
  logic [15:0] rb_q, rb_n;

  assign hit = (host_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
  assign off = host_addr[2:0];

  assign wr_regsel = host_we && hit && (off == OFF_REGSEL);
  assign wr_physel = host_we && hit && (off == OFF_PHYSEL);
  assign wr_dlo    = host_we && hit && (off == OFF_DLO);
  assign wr_dhi    = host_we && hit && (off == OFF_DHI);
  assign wr_ctrl   = host_we && hit && (off == OFF_CTRL);
  assign wr_stat   = host_we && hit && (off == OFF_STAT);
  assign cfg_wr    = wr_regsel || wr_physel || wr_dlo || wr_dhi;

  assign launch = wr_dhi && !busy && !lo_last_q;

  always_comb begin
    regsel_n  = regsel_q;
    physel_n  = physel_q;
    dlo_n     = dlo_q;
    dhi_n     = dhi_q;
    verify_n  = verify_q;
    rb_n      = rb_q;
    vfail_n   = vfail_q;
    wwb_n     = wwb_q;
    hazard_n  = hazard_q;
    early_n   = early_q;
    pending_n = pending_q;
    lo_last_n = wr_dlo && !busy;

    if (!busy) begin
      if (wr_regsel) regsel_n = host_wdata[4:0];
      if (wr_physel) physel_n = host_wdata[4:0];
      if (wr_dlo)    dlo_n    = host_wdata;
      if (launch)    dhi_n    = host_wdata;
    end
    if (wr_ctrl) verify_n = host_wdata[0];
    if (rb_load) rb_n = rb_val;

    if (wr_dlo && !busy) pending_n = 1'b1;
    else if (launch)     pending_n = 1'b0;

    if (wr_stat && host_wdata[1]) vfail_n = 1'b0;
    if (vfail_set)                vfail_n = 1'b1;
    if (wr_stat && host_wdata[2]) wwb_n = 1'b0;
    if (cfg_wr && busy)           wwb_n = 1'b1;
    if (wr_stat && host_wdata[3]) hazard_n = 1'b0;
    if (pending_q && (host_we || host_re) && (host_addr[5:0] == HAZARD_LOW6))
      hazard_n = 1'b1;
    if (wr_stat && host_wdata[4]) early_n = 1'b0;
    if (wr_dhi && !busy && lo_last_q) early_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regsel_q  <= '0;
      physel_q  <= '0;
      dlo_q     <= '0;
      dhi_q     <= '0;
      verify_q  <= 1'b0;
      rb_q      <= '0;
      vfail_q   <= 1'b0;
      wwb_q     <= 1'b0;
      hazard_q  <= 1'b0;
      early_q   <= 1'b0;
      pending_q <= 1'b0;
      lo_last_q <= 1'b0;
    end else begin
      regsel_q  <= regsel_n;
      physel_q  <= physel_n;
      dlo_q     <= dlo_n;
      dhi_q     <= dhi_n;
      verify_q  <= verify_n;
      rb_q      <= rb_n;
      vfail_q   <= vfail_n;
      wwb_q     <= wwb_n;
      hazard_q  <= hazard_n;
      early_q   <= early_n;
      pending_q <= pending_n;
      lo_last_q <= lo_last_n;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (hit) begin
      case (off)
        OFF_REGSEL: host_rdata = {3'b000, regsel_q};
        OFF_PHYSEL: host_rdata = {3'b000, physel_q};
        OFF_DLO:    host_rdata = dlo_q;
        OFF_DHI:    host_rdata = dhi_q;
        OFF_CTRL:   host_rdata = {7'b0, verify_q};
        OFF_STAT:   host_rdata = {3'b000, early_q, hazard_q, wwb_q, vfail_q, busy};
        OFF_RBLO:   host_rdata = rb_q[7:0];
        default:    host_rdata = rb_q[15:8];
      endcase
    end
  end

  assign verify_en  = verify_q;
  assign stage_data = {dhi_q, dlo_q};
  assign phy_addr   = physel_q;
  assign reg_addr   = regsel_q;

  // R9: staged low byte is untouched by a write that arrives while busy
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && hit && (off == OFF_DLO)) |=> $stable(dlo_q));

  // R6: hazard flag stays set until software clears it
  p_hazard_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hazard_q && !(wr_stat && host_wdata[3])) |=> hazard_q);
endmodule

// File: rtl/mdio_wv_ctl.sv
module mdio_wv_ctl
  import mdio_wv_pkg::*;
#(
  parameter int MAX_TRY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic        verify_en,
  input  logic [15:0] stage_data,
  input  logic        eng_done,
  input  logic [15:0] eng_rdata,
  output logic        eng_start,
  output logic        eng_rd,
  output logic        busy,
  output logic        vfail_set,
  output logic        rb_load
);
  localparam int TRY_W = $clog2(MAX_TRY + 1);

  seq_state_t       st_q, st_n;
  logic [TRY_W-1:0] tries_q, tries_n;
  logic             start_q, start_n, rd_q, rd_n;

  always_comb begin
    st_n      = st_q;
    tries_n   = tries_q;
    start_n   = 1'b0;
    rd_n      = rd_q;
    vfail_set = 1'b0;
    rb_load   = 1'b0;
    case (st_q)
      SQ_IDLE: if (launch) begin
        st_n    = SQ_WRITE;
        tries_n = TRY_W'(1);
        start_n = 1'b1;
        rd_n    = 1'b0;
      end
      SQ_WRITE: if (eng_done) begin
        if (verify_en) begin
          st_n    = SQ_READ;
          start_n = 1'b1;
          rd_n    = 1'b1;
        end else begin
          st_n = SQ_IDLE;
        end
      end
      SQ_READ: if (eng_done) begin
        rb_load = 1'b1;
        if (eng_rdata == stage_data) begin
          st_n = SQ_IDLE;
        end else if (tries_q == TRY_W'(MAX_TRY)) begin
          vfail_set = 1'b1;
          st_n      = SQ_IDLE;
        end else begin
          tries_n = tries_q + TRY_W'(1);
          st_n    = SQ_WRITE;
          start_n = 1'b1;
          rd_n    = 1'b0;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      tries_q <= '0;
      start_q <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      tries_q <= tries_n;
      start_q <= start_n;
      rd_q    <= rd_n;
    end
  end

  assign eng_start = start_q;
  assign eng_rd    = rd_q;
  assign busy      = (st_q != SQ_IDLE);

  // R4: busy is visible the cycle after an accepted commit
  p_busy_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R8: the attempt count never exceeds the limit
  p_tries_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_W'(MAX_TRY));
endmodule

// File: rtl/mdio_wv_engine.sv
module mdio_wv_engine
  import mdio_wv_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rdata
);
  localparam int HALF = DIV / 2;
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BC_W = $clog2(FRAME_BITS);

  logic                  sending_q, sending_n, rd_q, rd_n, mdc_q, mdc_n, tick;
  logic [FRAME_BITS-1:0] frame_q, frame_n;
  logic [BC_W-1:0]       bit_q, bit_n;
  logic [HC_W-1:0]       hc_q, hc_n;
  logic [15:0]           rsh_q, rsh_n;

  assign tick = sending_q && (hc_q == HC_W'(HALF - 1));

  always_comb begin
    sending_n = sending_q;
    rd_n      = rd_q;
    mdc_n     = mdc_q;
    frame_n   = frame_q;
    bit_n     = bit_q;
    hc_n      = hc_q;
    rsh_n     = rsh_q;
    done      = 1'b0;
    if (!sending_q) begin
      if (start) begin
        sending_n = 1'b1;
        rd_n      = rd;
        mdc_n     = 1'b0;
        bit_n     = '0;
        hc_n      = '0;
        frame_n   = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy_addr, reg_addr,
                     2'b10, rd ? 16'hFFFF : wdata};
      end
    end else begin
      hc_n = tick ? '0 : hc_q + HC_W'(1);
      if (tick) begin
        if (!mdc_q) begin
          mdc_n = 1'b1;
          if (rd_q && (bit_q >= DATA_FIRST)) rsh_n = {rsh_q[14:0], mdio_i};
        end else begin
          mdc_n = 1'b0;
          if (bit_q == BC_W'(FRAME_BITS - 1)) begin
            sending_n = 1'b0;
            done      = 1'b1;
          end else begin
            bit_n   = bit_q + BC_W'(1);
            frame_n = {frame_q[FRAME_BITS-2:0], 1'b1};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending_q <= 1'b0;
      rd_q      <= 1'b0;
      mdc_q     <= 1'b0;
      frame_q   <= '0;
      bit_q     <= '0;
      hc_q      <= '0;
      rsh_q     <= '0;
    end else begin
      sending_q <= sending_n;
      rd_q      <= rd_n;
      mdc_q     <= mdc_n;
      frame_q   <= frame_n;
      bit_q     <= bit_n;
      hc_q      <= hc_n;
      rsh_q     <= rsh_n;
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = frame_q[FRAME_BITS-1];
  assign mdio_oe = sending_q && !(rd_q && (bit_q > DRIVE_LAST));
  assign rdata   = rsh_q;

  // R1: with no frame in flight the lines are quiet
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sending_q |-> (!mdc && !mdio_oe));

  // R3: data never changes across a rising MDC edge
  p_stable_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_wv_seq.sv
module mdio_wv_seq
  import mdio_wv_pkg::*;
#(
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] BASE    = 'hE80,
  parameter int                DIV     = 16,
  parameter int                MAX_TRY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        rst_m, rst_s;
  logic        busy, vfail_set, rb_load, launch, verify_en;
  logic        eng_start, eng_rd, eng_done;
  logic [15:0] stage_data, eng_rdata;
  logic [4:0]  phy_addr, reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  mdio_wv_regs #(.ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_s), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .vfail_set(vfail_set), .rb_load(rb_load), .rb_val(eng_rdata),
    .launch(launch), .verify_en(verify_en), .stage_data(stage_data),
    .phy_addr(phy_addr), .reg_addr(reg_addr)
  );

  mdio_wv_ctl #(.MAX_TRY(MAX_TRY)) u_ctl (
    .clk(clk), .rst_n(rst_s), .launch(launch), .verify_en(verify_en),
    .stage_data(stage_data), .eng_done(eng_done), .eng_rdata(eng_rdata),
    .eng_start(eng_start), .eng_rd(eng_rd), .busy(busy),
    .vfail_set(vfail_set), .rb_load(rb_load)
  );

  mdio_wv_engine #(.DIV(DIV)) u_eng (
    .clk(clk), .rst_n(rst_s), .start(eng_start), .rd(eng_rd),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(stage_data),
    .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(eng_done), .rdata(eng_rdata)
  );
endmodule

// File: tb/test_mdio_wv_seq.sv
module test_mdio_wv_seq;
  localparam int          ADDR_W  = 12;
  localparam logic [11:0] BASE    = 12'hE80;
  localparam int          DIV     = 4;
  localparam int          MAX_TRY = 3;

  logic clk, rst_n, host_we, host_re, mdio_i;
  logic [11:0] host_addr;
  logic [7:0]  host_wdata, host_rdata, rdv;
  logic mdc, mdio_o, mdio_oe;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  logic [15:0] phy_mem[32];
  logic [63:0] cur, cap;
  logic [15:0] rv, mdl_staged, corrupt_mask, last_rb;
  int  pos, corrupt_left, mdl_tries, frames_done, mdc_per, last_rise;
  bit  inf, ok, is_rd, prev_mdc, mdl_verify, mdl_vfail;

  mdio_wv_seq #(.ADDR_W(ADDR_W), .BASE(BASE), .DIV(DIV), .MAX_TRY(MAX_TRY)) i_mdio_wv_seq (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  function automatic logic [63:0] mk(input bit r, input logic [4:0] p,
                                     input logic [4:0] g, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g, 2'b10, d};
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // behavioural PHY and frame reference, sampled on the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_mdc = 1'b0; inf = 1'b0; mdio_i = 1'b1;
    end else begin
      if (inf && is_rd && pos >= 47 && mdio_oe) begin
        checks++; failures++;
        $display("FAIL R10 bus contention actual=1 expected=0");
      end
      if (mdc && !prev_mdc) begin
        if (inf) mdc_per = cyc - last_rise;
        last_rise = cyc;
        if (!inf && mdio_oe) begin
          inf = 1'b1; pos = 0; ok = 1'b1; cap = '0;
          if (exp_q.size() == 0) begin ok = 1'b0; cur = '0; end
          else cur = exp_q.pop_front();
        end
        if (inf) begin
          is_rd = (cur[29:28] == 2'b10);
          cap = {cap[62:0], mdio_oe ? mdio_o : 1'b1};
          if (!is_rd || pos < 46) begin
            if (!mdio_oe || mdio_o !== cur[63-pos]) ok = 1'b0;
          end else if (mdio_oe) ok = 1'b0;
          if (pos == 35 && is_rd) begin
            rv = phy_mem[cur[22:18]];
            if (corrupt_left > 0) begin rv = rv ^ corrupt_mask; corrupt_left--; end
          end
          if (is_rd && pos + 1 == 47) mdio_i = 1'b0;
          else if (is_rd && pos + 1 >= 48 && pos + 1 <= 63) mdio_i = rv[15-(pos+1-48)];
          else mdio_i = 1'b1;
          if (pos == 63) begin
            checks++;
            if (!ok) begin
              failures++;
              $display("FAIL R3 frame actual=%h expected=%h", cap, cur);
            end
            frames_done++;
            inf = 1'b0; mdio_i = 1'b1;
            if (!is_rd) begin
              phy_mem[cur[22:18]] = cur[15:0];
              if (mdl_verify) exp_q.push_back(mk(1'b1, cur[27:23], cur[22:18], 16'hFFFF));
            end else begin
              last_rb = rv;
              if (rv != mdl_staged) begin
                if (mdl_tries < MAX_TRY) begin
                  mdl_tries++;
                  exp_q.push_back(mk(1'b0, cur[27:23], cur[22:18], mdl_staged));
                end else mdl_vfail = 1'b1;
              end
            end
          end
          pos++;
        end
      end
      prev_mdc = mdc;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    host_addr = a; host_re = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic launch(input logic [4:0] p, input logic [4:0] g, input logic [15:0] d);
    wr(BASE + 12'd0, {3'b0, g});
    wr(BASE + 12'd1, {3'b0, p});
    wr(BASE + 12'd2, d[7:0]);
    @(negedge clk);
    mdl_staged = d; mdl_tries = 1;
    exp_q.push_back(mk(1'b0, p, g, d));
    wr(BASE + 12'd3, d[15:8]);
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 20000; i++) begin
      rd(BASE + 12'd5, rdv);
      if (rdv[0] == 1'b0) break;
    end
    chk({req, " busy held to end of operation"}, int'(exp_q.size() == 0 && !inf), 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int f0;
    rst_n = 1'b0; host_we = 1'b0; host_re = 1'b0; host_addr = '0; host_wdata = '0;
    frames_done = 0; corrupt_left = 0; corrupt_mask = 16'h0100; mdl_verify = 0;
    mdl_vfail = 0; mdc_per = 0; last_rise = 0; pos = 0; mdl_tries = 0;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(BASE + 12'd5, rdv);
    chk("R1 status after reset", rdv, 8'h00);
    chk("R1 mdc low", mdc, 0);
    chk("R1 mdio_oe low", mdio_oe, 0);

    // R2, R4, R10: plain write
    launch(5'd3, 5'd5, 16'h1234);
    rd(BASE + 12'd5, rdv);
    chk("R4 busy within two cycles", rdv[0], 1);
    repeat (100) @(negedge clk);
    rd(BASE + 12'd5, rdv);
    chk("R4 busy mid frame", rdv[0], 1);
    wait_idle("R4");
    chk("R2 PHY register written", phy_mem[5], 16'h1234);
    chk("R10 mdc period", mdc_per, DIV);

    // R9: writes while busy are ignored
    launch(5'd3, 5'd7, 16'hBEEF);
    wr(BASE + 12'd2, 8'h77);
    wr(BASE + 12'd0, 8'h01);
    wait_idle("R9");
    rd(BASE + 12'd5, rdv);
    chk("R9 write-while-busy flag", rdv[2], 1);
    rd(BASE + 12'd0, rdv);
    chk("R9 register select kept", rdv, 8'h07);
    wr(BASE + 12'd5, 8'h04);
    rd(BASE + 12'd5, rdv);
    chk("R9 flag cleared by write-one", rdv[2], 0);
    mdl_staged = 16'h55EF;
    exp_q.push_back(mk(1'b0, 5'd3, 5'd7, 16'h55EF));
    wr(BASE + 12'd3, 8'h55);
    wait_idle("R9");
    chk("R9 staged low byte intact", phy_mem[7], 16'h55EF);

    // R5: commit right after the low byte
    f0 = frames_done;
    wr(BASE + 12'd2, 8'h11);
    wr(BASE + 12'd3, 8'h22);
    repeat (3) @(negedge clk);
    rd(BASE + 12'd5, rdv);
    chk("R5 early commit not started", rdv[0], 0);
    chk("R5 early flag", rdv[4], 1);
    repeat (4 * DIV) @(negedge clk);
    chk("R5 no frame sent", frames_done - f0, 0);
    wr(BASE + 12'd5, 8'h10);

    // R6: hazard accesses between the two bytes
    rd(BASE + 12'd5, rdv);
    chk("R6 no hazard flag yet", rdv[3], 0);
    wr(BASE + 12'd2, 8'hAB);
    rd(12'h036, rdv);
    wr(12'h5F6, 8'h00);
    @(negedge clk);
    mdl_staged = 16'h9CAB;
    exp_q.push_back(mk(1'b0, 5'd3, 5'd7, 16'h9CAB));
    wr(BASE + 12'd3, 8'h9C);
    wait_idle("R6");
    chk("R6 low byte intact after hazard", phy_mem[7], 16'h9CAB);
    rd(BASE + 12'd5, rdv);
    chk("R6 hazard flag set", rdv[3], 1);
    wr(BASE + 12'd5, 8'h08);

    // R7: verify with a good read-back
    wr(BASE + 12'd4, 8'h01);
    mdl_verify = 1;
    f0 = frames_done;
    launch(5'd2, 5'd9, 16'h0F0F);
    wait_idle("R7");
    chk("R7 write plus read frames", frames_done - f0, 2);
    rd(BASE + 12'd6, rdv);
    chk("R7 read-back low", rdv, 8'h0F);
    rd(BASE + 12'd5, rdv);
    chk("R7 no verify failure", rdv[1], 0);

    // R7: one corrupted read-back forces a retry
    corrupt_left = 1;
    f0 = frames_done;
    launch(5'd2, 5'd10, 16'hA5A5);
    wait_idle("R7");
    chk("R7 retry frame count", frames_done - f0, 4);
    rd(BASE + 12'd7, rdv);
    chk("R7 read-back high after retry", rdv, 8'hA5);
    rd(BASE + 12'd5, rdv);
    chk("R7 retry succeeded", rdv[1], 0);

    // R8: every read-back corrupted
    corrupt_left = 3;
    f0 = frames_done;
    launch(5'd2, 5'd11, 16'h3C3C);
    wait_idle("R8");
    chk("R8 attempts exhausted", frames_done - f0, 2 * MAX_TRY);
    rd(BASE + 12'd5, rdv);
    chk("R8 verify-fail set", rdv[1], int'(mdl_vfail));
    chk("R8 busy cleared", rdv[0], 0);
    rd(BASE + 12'd7, rdv);
    chk("R8 last read-back high", rdv, last_rb[15:8]);
    rd(BASE + 12'd6, rdv);
    chk("R8 last read-back low", rdv, 8'h3C);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule